// File: doc/BRIEF.md
# Neighbour Triplet Reader Memory

This block is a 2048-word by 12-bit memory that is written from a slow clock. On a separate fast clock, a small sequencer reads three words: the word at the live address and the words on either side of it. It places them in three registered outputs (left, middle, right), which feed a downstream arithmetic stage.

Each write is an ordinary single-port store at the live address. The fast side keeps the last address it saw. When the live address differs from that copy, the fast side restarts a three-step walk through the offsets -1, 0 and +1. It takes one fast edge per step, so each output register loads on its own edge. A flag tells the consumer when all three outputs belong to the current address.

Neighbour addresses wrap around the ends of the memory. Between address changes the sequencer rests in an idle step and leaves the outputs alone. The fast clock should run at least four times as fast as the slow clock, so that the walk finishes inside each slow period.

Top module: `nbr_triplet_mem`

## Requirements
- R1: After reset, the three outputs are zero and `trio_valid` is low. They stay that way until the fast side sees a live address that differs from 0, which is the address held in reset.
- R2: On a rising edge of `wr_clk` with `wr_en` high, `wr_data` is stored at `addr`. With `wr_en` low, that edge leaves the memory unchanged.
- R3: Call the fast edge that first samples a new `addr` value A the detect edge. `left_q` takes mem[A-1] on the next fast edge, `mid_q` takes mem[A] on the edge after that, and `right_q` takes mem[A+1] on the third fast edge after detection.
- R4: `trio_valid` rises on the same fast edge that loads `right_q`. It goes low on every detect edge.
- R5: Neighbour addresses wrap modulo 2048: address 0 has left neighbour 2047, and address 2047 has right neighbour 0.
- R6: Once the walk is complete and `addr` does not change, the outputs hold their values. This is true even if the location is written again.
- R7: An address change in the middle of a walk abandons that walk. The walk restarts from the left neighbour of the new address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Slow write clock |
| rd_clk | input | 1 | Fast read/sequencer clock |
| rst_n | input | 1 | Active-low asynchronous reset of the fast-side state |
| wr_en | input | 1 | Write enable, sampled on `wr_clk` |
| addr | input | 11 | Live address for writes and walk centre |
| wr_data | input | 12 | Word to store |
| left_q | output | 12 | Word at addr-1 |
| mid_q | output | 12 | Word at addr |
| right_q | output | 12 | Word at addr+1 |
| trio_valid | output | 1 | All three outputs belong to the current address |

## Verification
The bench first fills every location in a walk across the whole memory, with each address held long enough for a complete walk. This exercises the ordinary three-step sequence everywhere, including both wrap points. A second pattern rewrites the same address with new data and disabled writes. It separates a design that ignores same-address traffic from one that re-reads it, and a write that honours `wr_en` from one that does not. A third pattern changes the address after only two fast edges. It shows whether a partly finished walk is dropped cleanly, or whether stale left or middle words and an early valid flag leak through.

// File: rtl/nbr_triplet_mem.sv
module nbr_triplet_mem #(
  parameter int AW = 11,
  parameter int DW = 12
) (
  input  logic          wr_clk,
  input  logic          rd_clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] left_q,
  output logic [DW-1:0] mid_q,
  output logic [DW-1:0] right_q,
  output logic          trio_valid
);
  localparam int DEPTH = 1 << AW;
  localparam logic [1:0] IDLE = 2'd3;

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] last_addr;
  logic [1:0]    step;
  logic          addr_chg;
  logic [AW-1:0] rd_addr;
  logic [DW-1:0] rd_word;

  always_ff @(posedge wr_clk)
    if (wr_en) mem[addr] <= wr_data;

  assign addr_chg = (addr != last_addr);
  assign rd_addr  = addr + {{(AW-2){1'b0}}, step} - {{(AW-1){1'b0}}, 1'b1};
  assign rd_word  = mem[rd_addr];

  always_ff @(posedge rd_clk or negedge rst_n) begin
    if (!rst_n) begin
      last_addr <= '0;
      step      <= IDLE;
    end else if (addr_chg) begin
      last_addr <= addr;
      step      <= 2'd0;
    end else if (step != IDLE) begin
      step      <= step + 2'd1;
    end
  end

  always_ff @(posedge rd_clk or negedge rst_n) begin
    if (!rst_n) begin
      left_q     <= '0;
      mid_q      <= '0;
      right_q    <= '0;
      trio_valid <= 1'b0;
    end else if (addr_chg) begin
      trio_valid <= 1'b0;
    end else begin
      case (step)
        2'd0: left_q <= rd_word;
        2'd1: mid_q  <= rd_word;
        2'd2: begin
          right_q    <= rd_word;
          trio_valid <= 1'b1;
        end
        default: ;
      endcase
    end
  end
endmodule

module nbr_triplet_mem_chk #(
  parameter int AW = 11,
  parameter int DW = 12
) (
  input logic          rd_clk,
  input logic          rst_n,
  input logic [AW-1:0] addr,
  input logic [AW-1:0] last_addr,
  input logic [1:0]    step,
  input logic [DW-1:0] left_q,
  input logic [DW-1:0] mid_q,
  input logic [DW-1:0] right_q,
  input logic          trio_valid
);
  // R4
  valid_clear_chk: assert property (@(posedge rd_clk) disable iff (!rst_n)
    (addr != last_addr) |=> !trio_valid);

  // R4
  valid_idle_chk: assert property (@(posedge rd_clk) disable iff (!rst_n)
    trio_valid |-> (step == 2'd3));

  // R6
  hold_outputs_chk: assert property (@(posedge rd_clk) disable iff (!rst_n)
    (step == 2'd3 && addr == last_addr) |=>
      ($stable(left_q) && $stable(mid_q) && $stable(right_q) && $stable(trio_valid)));

  // R1
  idle_stays_chk: assert property (@(posedge rd_clk) disable iff (!rst_n)
    (step == 2'd3 && addr == last_addr) |=> (step == 2'd3));

  // R7
  restart_walk_chk: assert property (@(posedge rd_clk) disable iff (!rst_n)
    (addr != last_addr) |=> (step == 2'd0 && last_addr == $past(addr)));
endmodule

bind nbr_triplet_mem nbr_triplet_mem_chk #(.AW(AW), .DW(DW)) u_chk (
  .rd_clk(rd_clk), .rst_n(rst_n), .addr(addr), .last_addr(last_addr),
  .step(step), .left_q(left_q), .mid_q(mid_q), .right_q(right_q),
  .trio_valid(trio_valid)
);

// File: tb/nbr_triplet_mem_bench.sv
`timescale 1ns/1ps
module nbr_triplet_mem_bench;
  logic        wr_clk = 0, rd_clk = 0, rst_n = 0, wr_en = 0;
  logic [10:0] addr = '0;
  logic [11:0] wr_data = '0;
  logic [11:0] left_q, mid_q, right_q;
  logic        trio_valid;

  int n_chk = 0, n_bad = 0;
  bit chk_on = 0, done = 0;

  nbr_triplet_mem u_nbr_triplet_mem (
    .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n), .wr_en(wr_en),
    .addr(addr), .wr_data(wr_data), .left_q(left_q), .mid_q(mid_q),
    .right_q(right_q), .trio_valid(trio_valid));

  always #5 rd_clk = ~rd_clk;

  logic [11:0] mm [2048];
  int          seen, age;
  logic [11:0] e_l, e_m, e_r;
  bit          e_v;

  always @(posedge wr_clk) if (wr_en) mm[addr] = wr_data;

  always @(posedge rd_clk) begin
    if (!rst_n) begin
      seen = 0; age = 99; e_l = 0; e_m = 0; e_r = 0; e_v = 0;
    end else if (int'(addr) != seen) begin
      seen = int'(addr); age = 0; e_v = 0;
    end else begin
      if (age < 99) age++;
      if (age == 1) e_l = mm[(seen + 2047) % 2048];
      if (age == 2) e_m = mm[seen];
      if (age == 3) begin e_r = mm[(seen + 1) % 2048]; e_v = 1; end
    end
  end

  task automatic check(string req, string what, logic [11:0] act, logic [11:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge rd_clk) if (chk_on) begin
    check("R3", "left_q", left_q, e_l);
    check("R3", "mid_q", mid_q, e_m);
    check("R3", "right_q", right_q, e_r);
    check("R4", "trio_valid", {11'd0, trio_valid}, {11'd0, e_v});
  end

  task automatic drive(int a, int d, bit we, int n);
    @(posedge rd_clk); #3;
    addr = 11'(a); wr_data = 12'(d); wr_en = we; wr_clk = 1;
    @(posedge rd_clk); #3;
    wr_clk = 0;
    repeat (n - 1) @(posedge rd_clk);
  endtask

  task automatic trio(string req, int a);
    #5;
    check(req, "left", left_q, mm[(a + 2047) % 2048]);
    check(req, "mid", mid_q, mm[a]);
    check(req, "right", right_q, mm[(a + 1) % 2048]);
    check(req, "valid", {11'd0, trio_valid}, 12'd1);
  endtask

  initial begin
    logic [11:0] keep;
    repeat (3) @(posedge rd_clk);
    #3 rst_n = 1;
    repeat (5) @(posedge rd_clk);
    #5;
    // R1: reset state and idle with address 0
    check("R1", "left_q", left_q, 12'd0);
    check("R1", "mid_q", mid_q, 12'd0);
    check("R1", "right_q", right_q, 12'd0);
    check("R1", "valid", {11'd0, trio_valid}, 12'd0);
    chk_on = 1;
    // R2 fill every location
    for (int i = 1; i < 2048; i++) drive(i, (i * 37 + 5) & 12'hfff, 1, 4);
    drive(0, 12'h5a5, 1, 4);
    drive(17, 12'h111, 0, 6);
    trio("R2", 17);
    // R5 wrap at both ends
    drive(0, 0, 0, 6);
    trio("R5", 0);
    drive(2047, 0, 0, 6);
    trio("R5", 2047);
    // R6 same-address rewrite leaves outputs alone
    drive(100, 12'h3c3, 1, 6);
    keep = mid_q;
    drive(100, 12'hc3c, 1, 6);
    #5 check("R6", "mid held", mid_q, keep);
    // R2 disabled write leaves memory unchanged
    drive(200, 12'hfed, 0, 6);
    trio("R2", 200);
    // R7 change mid-walk
    drive(300, 0, 0, 2);
    drive(400, 0, 0, 6);
    trio("R7", 400);
    drive(500, 0, 0, 1);
    drive(501, 0, 0, 1);
    drive(502, 0, 0, 6);
    trio("R7", 502);
    for (int i = 0; i < 40; i++) drive((i * 613) % 2048, i * 91, i[0], 3 + (i % 4));
    drive(1000, 0, 0, 6);
    trio("R3", 1000);
    chk_on = 0;
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #1500000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule